// File: doc/BRIEF.md
# Sequential Eight-Channel Servo Pulse Generator

This block drives eight hobby-servo control lines from one counter by serving the channels in turn. It keeps an 8-bit position for each channel in a small local register file, and a simple write port updates that file: a channel number, a value and a one-cycle strobe. When the block serves a channel, it turns the stored position into a pulse length of sixteen clocks per position step on top of a fixed base of 3952 clocks. It holds that channel's line high for the whole length and then passes straight to the next channel.

The pulses follow each other with no gap. The frame period is the sum of the eight current pulse lengths, so it changes when the positions change. At a 4 MHz clock the pulse widths run from about 1 ms to about 2 ms. After reset a single idle interval of 4096 clocks passes with every line low, and then the first pulse starts on channel 0.

Top module: `servo_pulse_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all eight `pulse_o` lines are low. Every stored position resets to zero, so a channel that is never written produces 3952-cycle pulses.
- R2: After reset is released, `pulse_o` stays all-zero for exactly 4096 clock cycles. The first pulse then starts on channel 0.
- R3: Each pulse keeps its line high for exactly 16 × position + 3952 clock cycles.
- R4: Channels are served in ascending order 0, 1, …, 7 and then wrap back to 0, continuing without end.
- R5: When a pulse ends, the next channel's line rises in the same cycle that the previous line falls. Once the first pulse has started, `pulse_o` is never all-zero.
- R6: At most one bit of `pulse_o` is high in any cycle.
- R7: A channel's position is sampled when its pulse starts. A write that lands while that channel's pulse is running has no effect on the running pulse and takes effect on the channel's next turn. A write to a channel whose pulse has not yet started in the current round applies to that pulse.
- R8: A write with `set_en` high stores `set_pos` for channel `set_chan`. Channel n drives bit n of `pulse_o`.
- R9: Both ends of the range are exact: position 0 gives a 3952-cycle pulse and position 255 gives an 8032-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, assumed to be 4 MHz |
| rst_n | input | 1 | Synchronous reset, active low |
| set_en | input | 1 | One-cycle strobe that stores a position |
| set_chan | input | 3 | Channel number to write |
| set_pos | input | 8 | Position value to store |
| pulse_o | output | 8 | Servo control lines, bit n for channel n |

## Verification
`pulse_o` is registered. A line rises on the clock edge after the interval counter reaches its last cycle, so every result shows up one edge after the decision is made. The monitor samples on the falling clock edge and measures each run of a single line in samples, which equals the pulse length in cycles. It measures the idle run from the first sample after reset release, which gives 4096. A write is visible in the register file from the next edge, but it reaches the outputs only at the start of that channel's next pulse. The driver therefore pushes each expected pulse after the write that governs it and before that pulse ends, and the monitor pops the entry when it sees the line fall.

// File: rtl/servo_seq_pkg.sv
// Package: shared types for the sequential servo pulse generator.
// Assumes nothing beyond the two-phase life of the sequencer.
package servo_seq_pkg;

    // Sequencer phase: initial idle wait, then the endless pulse train.
    typedef enum logic {
        PH_WAIT  = 1'b0,
        PH_TRAIN = 1'b1
    } seq_phase_t;

endpackage

// File: rtl/servo_pos_file.sv
// Module: servo_pos_file
// Holds one position word for each channel. It has a single write port and
// a single combinational read port. Assumes the write channel is always
// below NUM_CH. Every entry resets to zero.
module servo_pos_file #(
    parameter int NUM_CH = 8,
    parameter int POS_W  = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [POS_W-1:0] wr_pos,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [POS_W-1:0] rd_pos
);

    logic [POS_W-1:0] entry_q [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
        // Store the new value when this entry is addressed; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry_q[g] <= '0;
            else if (wr_en && (wr_chan == CH_W'(g)))
                entry_q[g] <= wr_pos;
        end
    end

    // Combinational read of the addressed entry.
    always_comb rd_pos = entry_q[rd_chan];

    // R8: a write lands in the addressed entry on the following cycle.
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (entry_q[$past(wr_chan)] == $past(wr_pos)));

endmodule

// File: rtl/servo_len_calc.sv
// Module: servo_len_calc
// Maps a position word to a pulse length in clocks: the position shifted
// left by SCALE_SHIFT plus BASE_CYC. Purely combinational. Assumes CNT_W
// can hold the largest result.
module servo_len_calc #(
    parameter int POS_W       = 8,
    parameter int SCALE_SHIFT = 4,
    parameter int BASE_CYC    = 3952,
    parameter int CNT_W       = 13
) (
    input  logic [POS_W-1:0] pos,
    output logic [CNT_W-1:0] cycles
);

    // Scale and offset the position.
    always_comb cycles = CNT_W'(BASE_CYC) + (CNT_W'(pos) << SCALE_SHIFT);

endmodule

// File: rtl/servo_interval_timer.sv
// Module: servo_interval_timer
// Down-counter that marks the last cycle of each interval. On that cycle it
// reloads itself from load_len, so intervals follow each other with no gap.
// After reset the first interval is IDLE_CYC long. Assumes load_len >= 1.
module servo_interval_timer #(
    parameter int CNT_W    = 13,
    parameter int IDLE_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] load_len,
    output logic             last_cyc
);

    logic [CNT_W-1:0] remain_q;

    // Flag the final cycle of the current interval.
    always_comb last_cyc = (remain_q == CNT_W'(1));

    // Count down; reload on the final cycle; start with the idle interval.
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= CNT_W'(IDLE_CYC);
        else if (last_cyc)
            remain_q <= load_len;
        else
            remain_q <= remain_q - CNT_W'(1);
    end

    // R3: the counter never sits at zero.
    a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        remain_q != '0);

    // R3: one step down per cycle inside an interval.
    a_r3_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        !last_cyc |=> (remain_q == $past(remain_q) - CNT_W'(1)));

    // R3: a new interval starts with the length that was offered.
    a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
        last_cyc |=> (remain_q == $past(load_len)));

endmodule

// File: rtl/servo_pulse_seq.sv
// Module: servo_pulse_seq
// Top of the sequential servo pulse generator. It serves the channels in a
// fixed rotation, reads the served channel's position from the local file,
// turns it into a pulse length and drives that channel's line for exactly
// that many clocks. Assumes a 4 MHz clock for the 1-2 ms pulse range.
module servo_pulse_seq
    import servo_seq_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int POS_W       = 8,
    parameter int SCALE_SHIFT = 4,
    parameter int BASE_CYC    = 3952,
    parameter int IDLE_CYC    = 4096,
    localparam int CH_W       = $clog2(NUM_CH),
    localparam int MAX_PULSE  = ((2**POS_W) - 1) * (2**SCALE_SHIFT) + BASE_CYC,
    localparam int TOP_CYC    = (MAX_PULSE > IDLE_CYC) ? MAX_PULSE : IDLE_CYC,
    localparam int CNT_W      = $clog2(TOP_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [CH_W-1:0]   set_chan,
    input  logic [POS_W-1:0]  set_pos,
    output logic [NUM_CH-1:0] pulse_o
);

    logic [CH_W-1:0]   serve_q;
    logic [POS_W-1:0]  serve_pos;
    logic [CNT_W-1:0]  serve_len;
    logic              last_cyc;
    logic [NUM_CH-1:0] line_q;
    seq_phase_t        phase_q;

    servo_pos_file #(
        .NUM_CH (NUM_CH),
        .POS_W  (POS_W)
    ) i_pos_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (set_en),
        .wr_chan (set_chan),
        .wr_pos  (set_pos),
        .rd_chan (serve_q),
        .rd_pos  (serve_pos)
    );

    servo_len_calc #(
        .POS_W       (POS_W),
        .SCALE_SHIFT (SCALE_SHIFT),
        .BASE_CYC    (BASE_CYC),
        .CNT_W       (CNT_W)
    ) i_len_calc (
        .pos    (serve_pos),
        .cycles (serve_len)
    );

    servo_interval_timer #(
        .CNT_W    (CNT_W),
        .IDLE_CYC (IDLE_CYC)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_len (serve_len),
        .last_cyc (last_cyc)
    );

    // Advance the served channel at each interval boundary, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            serve_q <= '0;
        else if (last_cyc)
            serve_q <= (serve_q == CH_W'(NUM_CH - 1)) ? '0 : serve_q + CH_W'(1);
    end

    // Drop the old line and raise the served channel's line at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= '0;
        else if (last_cyc)
            line_q <= NUM_CH'(1) << serve_q;
    end

    // Leave the idle wait at the first boundary and never return to it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_WAIT;
        else if (last_cyc)
            phase_q <= PH_TRAIN;
    end

    // Drive the outputs from the line register.
    always_comb pulse_o = line_q;

    // R6: never more than one line high.
    a_r6_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulse_o));

    // R2: every line stays low during the idle wait.
    a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WAIT) |-> (pulse_o == '0));

    // R5: once a line is high, some line stays high.
    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_o != '0) |=> (pulse_o != '0));

    // R4: at a boundary during the train the high line moves up by one, wrapping.
    a_r4_rotation: assert property (@(posedge clk) disable iff (!rst_n)
        (last_cyc && (pulse_o != '0)) |=>
            (pulse_o == {$past(pulse_o[NUM_CH-2:0]), $past(pulse_o[NUM_CH-1])}));

    // R5: between boundaries the lines hold steady.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !last_cyc |=> $stable(pulse_o));

endmodule

// File: tb/test_servo_pulse_seq.sv
// Scoreboard bench: the driver pushes expected (channel, length) pulses and
// the monitor pops and compares them as pulses finish on the outputs.
module test_servo_pulse_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       set_en = 1'b0;
    logic [2:0] set_chan = '0;
    logic [7:0] set_pos = '0;
    logic [7:0] pulse_o;

    int compared = 0;
    int mismatched = 0;
    int exp_ch[$];
    int exp_len[$];
    int pulses_seen = 0;
    bit driver_done = 1'b0;
    bit finished = 1'b0;
    int multi_high = 0;

    always #2.5 clk = ~clk;

    servo_pulse_seq i_servo_pulse_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_chan (set_chan),
        .set_pos  (set_pos),
        .pulse_o  (pulse_o)
    );

    function automatic int pulse_len(int p);
        return 16 * p + 3952;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic write_pos(int ch, int p);
        @(negedge clk);
        set_en = 1'b1; set_chan = 3'(ch); set_pos = 8'(p);
        @(negedge clk);
        set_en = 1'b0;
    endtask

    task automatic push(int ch, int p);
        exp_ch.push_back(ch);
        exp_len.push_back(pulse_len(p));
    endtask

    // Driver: reset, writes, and expected pulses.
    initial begin
        repeat (3) @(negedge clk);
        check(pulse_o == 8'h00, "R1 reset lines low", int'(pulse_o), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(pulse_o == 8'h00, "R1 lines low after release", int'(pulse_o), 0);
        // Initial positions during the idle wait; channel 7 left at reset (R1).
        write_pos(0, 0);     // R9 low end
        write_pos(1, 255);   // R9 high end
        write_pos(2, 10);
        write_pos(3, 100);
        write_pos(4, 1);
        write_pos(5, 200);
        write_pos(6, 50);
        push(0, 0);
        push(1, 255);
        // R7: during channel 2's pulse, rewrite channel 2 (next turn) and 6 (this round).
        wait (pulse_o[2] === 1'b1);
        write_pos(2, 77);
        write_pos(6, 20);
        push(2, 10);
        push(3, 100); push(4, 1); push(5, 200); push(6, 20); push(7, 0);
        push(0, 0); push(1, 255); push(2, 77); push(3, 100);
        push(4, 1); push(5, 200); push(6, 20); push(7, 0);
        driver_done = 1'b1;
    end

    // Monitor: measure each run of outputs on the falling edge.
    initial begin
        logic [7:0] cur;
        int run;
        bit started;
        cur = '0; run = 0; started = 1'b0;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if ($countones(pulse_o) > 1) multi_high++;
            if (pulse_o !== cur) begin
                if (!started) begin
                    started = 1'b1;
                    check(run == 4096, "R2 idle length", run, 4096);
                    check(pulse_o == 8'h01, "R2 first channel", int'(pulse_o), 1);
                end else begin
                    int ch;
                    ch = 0;
                    for (int b = 7; b >= 0; b--) if (cur[b]) ch = b;
                    check(pulse_o != 8'h00, "R5 no gap", int'(pulse_o), 1);
                    if (exp_ch.size() > 0) begin
                        int ec, el;
                        ec = exp_ch.pop_front();
                        el = exp_len.pop_front();
                        check(ch == ec, "R4/R8 channel order", ch, ec);
                        check(run == el, "R3/R7/R9 pulse length", run, el);
                        pulses_seen++;
                    end
                end
                cur = pulse_o;
                run = 1;
            end else begin
                run++;
            end
        end
    end

    // Completion and summary.
    initial begin
        wait (driver_done && pulses_seen == 16);
        @(negedge clk);
        check(multi_high == 0, "R6 single line", multi_high, 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog timeout", pulses_seen, 16);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule